// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the bus side of a 16-bit processor whose address and data share one set of lines, with a 20-bit address space. A core-side request names a read or write, memory or I/O space, byte or word width, the address, a two-bit segment code, the current interrupt-enable state and the write data. The block steps through the T-states of one machine cycle. It emits an address strobe, the shared lines, the upper address/status lines, the read and write strobes, the space select, the transfer direction, the transceiver enable and the high-byte enable. It stretches the cycle with wait states while the READY input is low.

A second bus master can request the bus. The block lets the cycle in flight finish, floats every bus output and then grants. A request still pending at the end of a cycle starts the next cycle at once, with no idle state in between. Read data is latched from the shared lines at the end of the data phase and is returned with a one-cycle completion pulse.

Top module: `mux_bus_ctrl`

## Requirements
- R1: In T1 (the first cycle after a request is taken) ale_o is 1, ad_oe_o is 1, ad_o carries address bits 15:0, ahs_o carries address bits 19:16, and rd_n_o, wr_n_o and den_n_o are all 1.
- R2: In T2, T3, every wait state and T4, ale_o is 0 and den_n_o is 0. For a write, ad_oe_o is 1 and ad_o carries the write data. For a read, ad_oe_o is 0.
- R3: From T2 to T4, ahs_o carries status: bits 1:0 hold the segment code, bit 2 holds the interrupt-enable value captured with the request, and bit 3 is 0.
- R4: mio_o is 1 for memory and 0 for I/O throughout the cycle. rd_n_o is 0 in T2, T3 and wait states of a read, and wr_n_o is 0 in those states of a write. Both strobes are 1 in T1 and T4, and they are never 0 together.
- R5: dtr_o is 0 from T1 to T4 of a read and 1 from T1 to T4 of a write.
- R6: ready_i is sampled at the clock edge that ends T3 and at the edge that ends each wait state. A 0 there adds one wait state with the strobes held, so a cycle with n wait states lasts 4+n clocks.
- R7: ad_i is latched at the edge that ends the data phase. done_o is 1 only during T4, and in T4 rdata_o holds the read data. A byte read returns the addressed lane (the upper byte when address bit 0 is 1) in bits 7:0, with bits 15:8 zero.
- R8: bhe_n_o is 0 for word accesses and for byte accesses at odd addresses, and 1 for byte accesses at even addresses. A byte write drives its data byte (write data bits 7:0) on both halves of ad_o.
- R9: hold_i is sampled when idle and at the end of T4. If it is 1 there, the block enters hold instead of starting a cycle, even when a request is pending. In hold, hlda_o is 1 and ad_oe_o, ahs_oe_o and ctl_oe_o are 0. A hold raised during a cycle takes effect only after that cycle's T4.
- R10: When idle, ale_o and done_o are 0, ad_oe_o is 0, and rd_n_o, wr_n_o and den_n_o are 1. After hold_i drops, the block returns to idle on the next clock and clears hlda_o.
- R11: A request that is high at the end of T4, with hold_i low, starts T1 on the next clock using the request fields present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a bus cycle, taken when idle or at end of T4 |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory space, 0 = I/O space |
| req_byte_i | input | 1 | 1 = byte access, 0 = word access |
| req_ie_i | input | 1 | Interrupt-enable value shown in status |
| req_seg_i | input | 2 | Segment code shown in status |
| req_addr_i | input | 20 | Cycle address |
| req_wdata_i | input | 16 | Write data (byte writes use bits 7:0) |
| ready_i | input | 1 | 0 inserts wait states |
| hold_i | input | 1 | Bus request from another master |
| ad_i | input | 16 | Shared lines as seen from the pads |
| hlda_o | output | 1 | Bus granted to the other master |
| ad_o | output | 16 | Shared lines drive value |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ahs_o | output | 4 | Upper address, then status |
| ahs_oe_o | output | 1 | Drive enable for ahs_o |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| dtr_o | output | 1 | Direction, 0 = receive |
| den_n_o | output | 1 | Transceiver enable, active low |
| bhe_n_o | output | 1 | Upper byte enable, active low |
| ctl_oe_o | output | 1 | Drive enable for control outputs |
| done_o | output | 1 | Cycle completes (T4) |
| rdata_o | output | 16 | Read data, valid with done_o |

## Verification
The hardest cases to reach are those that depend on what happens at the T4 boundary. One is a hold raised in the middle of a cycle, which must stay ungranted until T4 is over. Another is a request held high across T4, which must chain into a new T1 with different fields. The bench raises hold_i during T2 of a running read and checks that hlda_o stays low through T4 and rises one clock later. It also changes the request fields during T4 while keeping req_i high, and checks that the next address phase carries the new address. A sweep over direction, space, width, address parity and 0, 1 or 3 wait states covers lane steering and cycle length.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } bus_state_e;

  typedef struct packed {
    logic       wr;
    logic       mem;
    logic       byte_acc;
    logic       ie;
    logic [1:0] seg;
  } cyc_kind_t;
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  cyc_kind_t     kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ready_i,
  input  logic          hold_i,
  input  logic [DW-1:0] ad_i,
  output bus_state_e    state_o,
  output cyc_kind_t     kind_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rbus_o
);
  bus_state_e st_q, st_d;
  cyc_kind_t  kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rbus_q;
  logic boundary, take, data_end;

  assign boundary = (st_q == ST_IDLE) || (st_q == ST_T4);
  assign take     = boundary && !hold_i && req_i;
  assign data_end = ((st_q == ST_T3) || (st_q == ST_TW)) && ready_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_T4: st_d = hold_i ? ST_HOLD : (req_i ? ST_T1 : ST_IDLE);
      ST_T1:          st_d = ST_T2;
      ST_T2:          st_d = ST_T3;
      ST_T3, ST_TW:   st_d = ready_i ? ST_T4 : ST_TW;
      ST_HOLD:        st_d = hold_i ? ST_HOLD : ST_IDLE;
      default:        st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rbus_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        kind_q  <= kind_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (data_end) rbus_q <= ad_i;
    end
  end

  assign state_o = st_q;
  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rbus_o  = rbus_q;

  p_wait_insert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_T3) || (st_q == ST_TW)) && !ready_i |=> st_q == ST_TW);
  p_hold_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary && hold_i |=> st_q == ST_HOLD);
  p_chain_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T4) && req_i && !hold_i |=> st_q == ST_T1);
endmodule

// File: rtl/mbc_lane.sv
module mbc_lane #(
  parameter int DW = 16
) (
  input  logic          byte_acc_i,
  input  logic          odd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rbus_i,
  output logic [DW-1:0] wbus_o,
  output logic [DW-1:0] rdata_o
);
  localparam int HW = DW / 2;

  for (genvar g = 0; g < 2; g++) begin : g_wlane
    assign wbus_o[g*HW +: HW] = byte_acc_i ? wdata_i[HW-1:0] : wdata_i[g*HW +: HW];
  end

  always_comb begin
    if (!byte_acc_i)  rdata_o = rbus_i;
    else if (odd_i)   rdata_o = {{HW{1'b0}}, rbus_i[DW-1:HW]};
    else              rdata_o = {{HW{1'b0}}, rbus_i[HW-1:0]};
  end
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_state_e       state_i,
  input  cyc_kind_t        kind_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wbus_i,
  output logic             hlda_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [AW-DW-1:0] ahs_o,
  output logic             ahs_oe_o,
  output logic             ale_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             mio_o,
  output logic             dtr_o,
  output logic             den_n_o,
  output logic             bhe_n_o,
  output logic             ctl_oe_o,
  output logic             done_o
);
  localparam int UW = AW - DW;

  logic [UW-1:0] stat_w;
  logic in_cyc, strobe_ph, data_ph;

  always_comb begin
    stat_w      = '0;
    stat_w[1:0] = kind_i.seg;
    stat_w[2]   = kind_i.ie;
  end

  assign in_cyc    = (state_i != ST_IDLE) && (state_i != ST_HOLD);
  assign strobe_ph = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
  assign data_ph   = strobe_ph || (state_i == ST_T4);

  always_comb begin
    hlda_o   = (state_i == ST_HOLD);
    ctl_oe_o = !hlda_o;
    ahs_oe_o = !hlda_o;
    ale_o    = (state_i == ST_T1);
    done_o   = (state_i == ST_T4);
    ad_oe_o  = ale_o || (data_ph && kind_i.wr);
    ad_o     = ale_o ? addr_i[DW-1:0] : (data_ph && kind_i.wr ? wbus_i : '0);
    ahs_o    = ale_o ? addr_i[AW-1:DW] : (data_ph ? stat_w : '0);
    rd_n_o   = !(strobe_ph && !kind_i.wr);
    wr_n_o   = !(strobe_ph && kind_i.wr);
    den_n_o  = !data_ph;
    dtr_o    = in_cyc ? kind_i.wr : 1'b1;
    mio_o    = in_cyc ? kind_i.mem : 1'b1;
    bhe_n_o  = in_cyc ? (kind_i.byte_acc && !addr_i[0]) : 1'b1;
  end

  p_ale_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o && rd_n_o && wr_n_o && den_n_o);
  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_n_o || wr_n_o);
  p_read_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !dtr_o && !ad_oe_o);
  p_float_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !ad_oe_o && !ahs_oe_o && !ctl_oe_o && !done_o);
  p_done_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || ale_o == 1'b0);
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_wr_i,
  input  logic             req_mem_i,
  input  logic             req_byte_i,
  input  logic             req_ie_i,
  input  logic [1:0]       req_seg_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             ready_i,
  input  logic             hold_i,
  input  logic [DW-1:0]    ad_i,
  output logic             hlda_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [AW-DW-1:0] ahs_o,
  output logic             ahs_oe_o,
  output logic             ale_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             mio_o,
  output logic             dtr_o,
  output logic             den_n_o,
  output logic             bhe_n_o,
  output logic             ctl_oe_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o
);
  bus_state_e    state;
  cyc_kind_t     kind_in, kind;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rbus, wbus;

  assign kind_in = '{wr: req_wr_i, mem: req_mem_i, byte_acc: req_byte_i,
                     ie: req_ie_i, seg: req_seg_i};

  mbc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .kind_i  (kind_in),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .ready_i (ready_i),
    .hold_i  (hold_i),
    .ad_i    (ad_i),
    .state_o (state),
    .kind_o  (kind),
    .addr_o  (addr),
    .wdata_o (wdata),
    .rbus_o  (rbus)
  );

  mbc_lane #(.DW(DW)) u_lane (
    .byte_acc_i (kind.byte_acc),
    .odd_i      (addr[0]),
    .wdata_i    (wdata),
    .rbus_i     (rbus),
    .wbus_o     (wbus),
    .rdata_o    (rdata_o)
  );

  mbc_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .kind_i   (kind),
    .addr_i   (addr),
    .wbus_i   (wbus),
    .hlda_o   (hlda_o),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .ahs_o    (ahs_o),
    .ahs_oe_o (ahs_oe_o),
    .ale_o    (ale_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .mio_o    (mio_o),
    .dtr_o    (dtr_o),
    .den_n_o  (den_n_o),
    .bhe_n_o  (bhe_n_o),
    .ctl_oe_o (ctl_oe_o),
    .done_o   (done_o)
  );
endmodule

// File: tb/tb_mux_bus_ctrl.sv
module tb_mux_bus_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 0, req_wr_i = 0, req_mem_i = 0, req_byte_i = 0, req_ie_i = 0;
  logic [1:0]  req_seg_i = '0;
  logic [19:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0, ad_i = '0;
  logic ready_i = 1'b0, hold_i = 1'b0;
  logic hlda_o, ad_oe_o, ahs_oe_o, ale_o, rd_n_o, wr_n_o, mio_o, dtr_o;
  logic den_n_o, bhe_n_o, ctl_oe_o, done_o;
  logic [15:0] ad_o, rdata_o;
  logic [3:0]  ahs_o;
  int n_chk = 0, n_err = 0;

  always #5ns clk = ~clk;

  mux_bus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_wr_i(req_wr_i),
    .req_mem_i(req_mem_i), .req_byte_i(req_byte_i), .req_ie_i(req_ie_i),
    .req_seg_i(req_seg_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .ready_i(ready_i), .hold_i(hold_i), .ad_i(ad_i), .hlda_o(hlda_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ahs_o(ahs_o), .ahs_oe_o(ahs_oe_o),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .mio_o(mio_o),
    .dtr_o(dtr_o), .den_n_o(den_n_o), .bhe_n_o(bhe_n_o), .ctl_oe_o(ctl_oe_o),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R10 ale"}, ale_o, 0);
    chk({tag, " R10 done"}, done_o, 0);
    chk({tag, " R10 ad_oe"}, ad_oe_o, 0);
    chk({tag, " R10 strobes/den"}, {rd_n_o, wr_n_o, den_n_o}, 3'b111);
    chk({tag, " R10 hlda"}, hlda_o, 0);
  endtask

  // Called at a negedge; drives the request now, T1 follows at the next negedge.
  // Returns at the T4 negedge.
  task automatic run_cyc(input bit wr, input bit mem, input bit bt, input logic [19:0] a,
                         input logic [1:0] sg, input bit ie, input logic [15:0] wd,
                         input logic [15:0] rv, input int nw, input bit keep_req,
                         input bit hold_mid);
    logic [15:0] exp_w, exp_r;
    logic [3:0]  exp_st;
    exp_w  = bt ? {wd[7:0], wd[7:0]} : wd;
    exp_r  = !bt ? rv : (a[0] ? {8'h00, rv[15:8]} : {8'h00, rv[7:0]});
    exp_st = {1'b0, ie, sg};
    req_i = 1; req_wr_i = wr; req_mem_i = mem; req_byte_i = bt;
    req_addr_i = a; req_seg_i = sg; req_ie_i = ie; req_wdata_i = wd;
    @(negedge clk); // T1
    chk("R1 ale", ale_o, 1);
    chk("R1 ad_oe", ad_oe_o, 1);
    chk("R1 addr low", ad_o, a[15:0]);
    chk("R1 addr high", ahs_o, a[19:16]);
    chk("R1 strobes/den", {rd_n_o, wr_n_o, den_n_o}, 3'b111);
    chk("R4 mio T1", mio_o, mem);
    chk("R5 dtr T1", dtr_o, wr);
    chk("R8 bhe", bhe_n_o, bt && !a[0]);
    if (!keep_req) req_i = 0;
    ad_i = rv;
    ready_i = (nw == 0);
    @(negedge clk); // T2
    if (hold_mid) hold_i = 1;
    chk("R2 ale T2", ale_o, 0);
    chk("R2 den T2", den_n_o, 0);
    chk("R2 ad_oe T2", ad_oe_o, wr);
    if (wr) chk("R2/R8 wdata T2", ad_o, exp_w);
    chk("R3 status T2", ahs_o, exp_st);
    chk("R4 strobes T2", {rd_n_o, wr_n_o}, {wr, !wr});
    chk("R5 dtr T2", dtr_o, wr);
    @(negedge clk); // T3
    chk("R4 strobes T3", {rd_n_o, wr_n_o}, {wr, !wr});
    chk("R4 mio T3", mio_o, mem);
    chk("R6 no done T3", done_o, 0);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk); // TW
      chk("R6 wait strobes", {rd_n_o, wr_n_o}, {wr, !wr});
      chk("R6 wait no done", done_o, 0);
      chk("R3 status TW", ahs_o, exp_st);
      ready_i = (w == nw - 1);
    end
    @(negedge clk); // T4
    ready_i = 0;
    ad_i = ~rv;
    chk("R7 done T4", done_o, 1);
    if (!wr) chk("R7 rdata", rdata_o, exp_r);
    chk("R4 strobes T4", {rd_n_o, wr_n_o}, 2'b11);
    chk("R2 den T4", den_n_o, 0);
    chk("R5 dtr T4", dtr_o, wr);
    if (hold_mid) chk("R9 no grant mid-cycle", hlda_o, 0);
  endtask

  initial begin
    #500us;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int nw_tab[3];
    nw_tab = '{0, 1, 3};
    repeat (2) @(negedge clk);
    chk("R10 reset ale", ale_o, 0);
    chk("R10 reset strobes", {rd_n_o, wr_n_o, den_n_o}, 3'b111);
    chk("R9 reset hlda", hlda_o, 0);
    rst_ni = 1;
    @(negedge clk);
    chk_idle("idle after reset");

    // sweep: direction, space, width, parity, wait count
    for (int i = 0; i < 48; i++) begin
      logic [19:0] a;
      a = {i[3:0] ^ 4'hA, 16'h1230 + 16'(i * 37)};
      a[0] = i[3];
      run_cyc(i[0], i[1], i[2], a, 2'(i), i[4] ^ i[0], 16'hC35A ^ 16'(i * 263),
              16'h9E71 + 16'(i * 101), nw_tab[i / 16], 0, 0);
      @(negedge clk);
      chk_idle("sweep");
    end

    // R11 chained requests: fields changed during T4 with req held
    run_cyc(0, 1, 0, 20'h3_0100, 2'd1, 1, 16'h0, 16'hBEEF, 0, 1, 0);
    run_cyc(1, 0, 1, 20'hC_0A03, 2'd2, 0, 16'h00A5, 16'h0, 1, 0, 0);
    @(negedge clk);
    chk_idle("R11 after chain");

    // R9 hold while idle with pending request: hold wins
    hold_i = 1; req_i = 1; req_addr_i = 20'h7_7777; req_wr_i = 0;
    @(negedge clk);
    chk("R9 hlda idle", hlda_o, 1);
    chk("R9 float", {ad_oe_o, ahs_oe_o, ctl_oe_o}, 3'b000);
    chk("R9 no start", ale_o, 0);
    @(negedge clk);
    chk("R9 hold kept", {hlda_o, ale_o}, 2'b10);
    hold_i = 0;
    @(negedge clk);
    chk("R10 hlda released", hlda_o, 0);
    chk("R10 idle after hold", ale_o, 0);
    @(negedge clk);
    chk("R9 pending start after hold", ale_o, 1);
    chk("R1 pending addr", ad_o, 16'h7777);
    req_i = 0; ready_i = 1;
    repeat (3) @(negedge clk);
    ready_i = 0;
    @(negedge clk);
    chk_idle("after pending");

    // R9 hold raised mid-cycle
    run_cyc(0, 1, 0, 20'h5_4320, 2'd3, 1, 16'h0, 16'h1357, 1, 0, 1);
    @(negedge clk);
    chk("R9 grant after T4", hlda_o, 1);
    chk("R9 float after T4", {ad_oe_o, ahs_oe_o, ctl_oe_o}, 3'b000);
    hold_i = 0;
    @(negedge clk);
    chk_idle("R9 release");

    summary();
    $finish;
  end
endmodule